// File: doc/BRIEF.md
# Disk DMA Transfer Sequencer

This block carries out a single read or write command between a sector-addressed disk store and main memory. The register unit supplies the command: a packed disk position, a negative word count, a 16-bit bus address with two extension bits, an increment-inhibit flag and an interrupt-enable flag. A one-cycle `start` pulse launches the command. The sequencer first checks the drive, cylinder and sector fields. It then moves data one 16-bit word at a time through a valid/ready memory port and a valid/ready disk-word port.

While the command runs, the sequencer keeps the live word count, bus address and disk position on its outputs, so the register unit can show them. It brackets each sector on the disk side with an open pulse and a close pulse. The close pulse carries the number of words actually moved. When the command ends, the sequencer raises the two ready flags again, raises a one-cycle `done` pulse, and raises `irq` when interrupts are enabled. A controller reset returns it to idle at once.

Top module: `disk_xfer_seq`

## Requirements
- R1: The disk position is packed as drive in bits 15:13, cylinder in bits 12:5, surface in bit 4 and sector in bits 3:0. Before any traffic, the command fails with the following checks, taken in this priority order: a drive whose `drive_present` bit is 0 sets `err_bits[7]`. Otherwise a cylinder above 202 sets `err_bits[6]`. Otherwise a sector above 11 sets `err_bits[5]`. A failed check produces no memory or disk handshake and leaves the count, address and position unchanged.
- R2: `rdy` and `ardy` are 1 after reset, go to 0 on the edge that accepts `start`, stay 0 while `busy`, and return to 1 one cycle after `done`. `irq` pulses together with `done` exactly when `ie` was 1 at start.
- R3: The word count is two's complement negative. It is incremented after every word, and the command stops when it reaches zero. A zero count finishes with no traffic and no change to the position.
- R4: The memory byte address is `{ext, ba}` (18 bits). It grows by 2 after each word. A carry out of the 16-bit `ba` increments `ext` modulo 4.
- R5: With `inh_inc` set, `ba` and `ext` stay frozen, and every word uses the same address.
- R6: A memory byte address at or above `MEM_BYTES` aborts the command before that word is accessed, with `err_bits[10]`. The count and address stay at the failing word.
- R7: With `fn_write` = 0 (read), words taken from the disk port are written to memory in order, with `mem_we` = 1.
- R8: With `fn_write` = 1 (write), words read from memory (`mem_we` = 0) are sent to the disk port in order. `sec_words` at `sec_close` equals the number of words moved in that sector, including a partial last sector.
- R9: A sector holds `SEC_WORDS` (256) words. When a sector is full, `sec_close` is followed by `sec_open` for the next position.
- R10: After every sector, including a partial one, the sector number increments. It wraps from 11 to 0 into the surface, and the surface wraps from 1 to 0 into the cylinder. `da_out` shows the new position.
- R11: Advancing past cylinder 202 sets `err_bits[14]`, ends the command, and leaves `da_out` at the last sector moved.
- R12: A `start` pulse while `busy` is ignored.
- R13: `ctl_reset` returns the block to idle on the next edge. It sets `rdy` and `ardy` to 1 and clears `err_bits`, the count and the address. No port handshake is offered afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_reset | input | 1 | Synchronous controller reset |
| start | input | 1 | Launch pulse for one command |
| fn_write | input | 1 | 1 = memory to disk, 0 = disk to memory |
| da_in | input | 16 | Starting disk position |
| wc_in | input | 16 | Negative word count |
| ba_in | input | 16 | Starting bus address |
| ext_in | input | 2 | Bus address bits 17:16 |
| inh_inc | input | 1 | Freeze the bus address |
| ie | input | 1 | Interrupt enable |
| drive_present | input | N_DRIVES | One bit per attached drive |
| busy | output | 1 | Command in progress |
| rdy | output | 1 | Controller ready |
| ardy | output | 1 | Access ready |
| irq | output | 1 | Interrupt request pulse |
| done | output | 1 | End-of-command pulse |
| err_bits | output | 16 | Error flags of the last command |
| da_out | output | 16 | Live disk position |
| wc_out | output | 16 | Live word count |
| ba_out | output | 16 | Live bus address |
| ext_out | output | 2 | Live address extension |
| sec_open | output | 1 | A sector transfer begins at `da_out` |
| sec_close | output | 1 | A sector transfer ends |
| sec_words | output | $clog2(SEC_WORDS)+1 | Words moved in the closing sector |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 18 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with the accept |
| dsk_rd_valid | input | 1 | Disk word available |
| dsk_rd_ready | output | 1 | Disk word taken |
| dsk_rd_data | input | 16 | Disk word |
| dsk_wr_valid | output | 1 | Word for the disk valid |
| dsk_wr_ready | input | 1 | Disk accepted the word |
| dsk_wr_data | output | 16 | Word for the disk |

## Verification
The bench targets the rollover points:
- a bus address that crosses 0xFFFE into the extension bits, where a design that drops the carry would fold back to the bottom 64 KiB;
- a sector 11 on surface 1, where a faulty wrap would skip or repeat a position;
- cylinder 202 on the last surface, where a design missing the overrun check would report a phantom cylinder 203.

Partial sectors in write mode show whether the close count follows the words actually moved rather than a full 256. Stalls on every port show whether words get lost or duplicated. Commands that are rejected, that carry a zero count, or that hit the memory limit show whether the design wrongly touches memory or moves its position. Start pulses during a run and a controller reset in mid-transfer expose a sequencer that restarts or keeps driving the ports.

// File: rtl/dxs_pkg.sv
package dxs_pkg;

  // Error flag bit positions, decoded by the register unit
  localparam int unsigned ERR_NODRV = 7;
  localparam int unsigned ERR_CYL   = 6;
  localparam int unsigned ERR_SEC   = 5;
  localparam int unsigned ERR_NXM   = 10;
  localparam int unsigned ERR_OVR   = 14;

  typedef struct packed {
    logic [2:0] drv;
    logic [7:0] cyl;
    logic       surf;
    logic [3:0] sec;
  } disk_pos_t;

  typedef struct packed {
    disk_pos_t pos;
    logic      ovf;
  } pos_step_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_SEC_OPEN, ST_WORD,
    ST_FETCH, ST_PUT, ST_SEC_CLOSE, ST_FINISH
  } seq_state_t;

  // Next disk position after one sector
  function automatic pos_step_t pos_advance(disk_pos_t p, int unsigned n_sec, int unsigned n_cyl);
    pos_step_t r;
    r.pos = p;
    r.ovf = 1'b0;
    if (32'(p.sec) + 1 >= n_sec) begin
      r.pos.sec = '0;
      if (p.surf) begin
        r.pos.surf = 1'b0;
        r.pos.cyl  = p.cyl + 8'd1;
        if (32'(p.cyl) + 1 >= n_cyl) r.ovf = 1'b1;
      end else begin
        r.pos.surf = 1'b1;
      end
    end else begin
      r.pos.sec = p.sec + 4'd1;
    end
    return r;
  endfunction

  // Next 18-bit byte address after one word
  function automatic logic [17:0] addr_step(logic [17:0] a, logic inh);
    return inh ? a : a + 18'd2;
  endfunction

endpackage

// File: rtl/dxs_pos_check.sv
module dxs_pos_check
  import dxs_pkg::*;
#(
  parameter int unsigned N_DRIVES = 8,
  parameter int unsigned N_CYL    = 203,
  parameter int unsigned N_SEC    = 12
) (
  input  disk_pos_t           pos,
  input  logic [N_DRIVES-1:0] present,
  output logic [15:0]         err_vec,
  output logic                bad
);

  always_comb begin
    err_vec = '0;
    if (!present[pos.drv])              err_vec[ERR_NODRV] = 1'b1;
    else if (32'(pos.cyl) >= N_CYL)     err_vec[ERR_CYL]   = 1'b1;
    else if (32'(pos.sec) >= N_SEC)     err_vec[ERR_SEC]   = 1'b1;
  end

  assign bad = |err_vec;

endmodule

// File: rtl/dxs_pos_step.sv
module dxs_pos_step
  import dxs_pkg::*;
#(
  parameter int unsigned N_CYL = 203,
  parameter int unsigned N_SEC = 12
) (
  input  disk_pos_t pos,
  output disk_pos_t next_pos,
  output logic      ovf
);

  pos_step_t r;

  always_comb begin
    r        = pos_advance(pos, N_SEC, N_CYL);
    next_pos = r.pos;
    ovf      = r.ovf;
  end

endmodule

// File: rtl/dxs_bus_addr.sv
module dxs_bus_addr
  import dxs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        load,
  input  logic [15:0] ba_in,
  input  logic [1:0]  ext_in,
  input  logic [15:0] wc_in,
  input  logic        inh_in,
  input  logic        step,
  output logic [17:0] addr,
  output logic [15:0] wc,
  output logic        wc_last,
  output logic        wc_zero
);

  logic [17:0] addr_q;
  logic [15:0] wc_q;
  logic        inh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wc_q   <= '0;
      inh_q  <= 1'b0;
    end else if (clr) begin
      addr_q <= '0;
      wc_q   <= '0;
      inh_q  <= 1'b0;
    end else if (load) begin
      addr_q <= {ext_in, ba_in};
      wc_q   <= wc_in;
      inh_q  <= inh_in;
    end else if (step) begin
      addr_q <= addr_step(addr_q, inh_q);
      wc_q   <= wc_q + 16'd1;
    end
  end

  assign addr    = addr_q;
  assign wc      = wc_q;
  assign wc_last = (wc_q == 16'hFFFF);
  assign wc_zero = (wc_q == 16'h0000);

  AST_INH_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (step && inh_q) |=> $stable(addr_q)); // R5

  AST_WC_COUNT: assert property (@(posedge clk) disable iff (!rst_n || clr)
    step |=> (wc_q == $past(wc_q) + 16'd1)); // R3

endmodule

// File: rtl/disk_xfer_seq.sv
module disk_xfer_seq
  import dxs_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 2**18 - 8192,
  parameter int unsigned N_DRIVES  = 8,
  parameter int unsigned N_CYL     = 203,
  parameter int unsigned N_SEC     = 12,
  parameter int unsigned SEC_WORDS = 256
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ctl_reset,
  input  logic                        start,
  input  logic                        fn_write,
  input  logic [15:0]                 da_in,
  input  logic [15:0]                 wc_in,
  input  logic [15:0]                 ba_in,
  input  logic [1:0]                  ext_in,
  input  logic                        inh_inc,
  input  logic                        ie,
  input  logic [N_DRIVES-1:0]         drive_present,
  output logic                        busy,
  output logic                        rdy,
  output logic                        ardy,
  output logic                        irq,
  output logic                        done,
  output logic [15:0]                 err_bits,
  output logic [15:0]                 da_out,
  output logic [15:0]                 wc_out,
  output logic [15:0]                 ba_out,
  output logic [1:0]                  ext_out,
  output logic                        sec_open,
  output logic                        sec_close,
  output logic [$clog2(SEC_WORDS):0]  sec_words,
  output logic                        mem_valid,
  input  logic                        mem_ready,
  output logic                        mem_we,
  output logic [17:0]                 mem_addr,
  output logic [15:0]                 mem_wdata,
  input  logic [15:0]                 mem_rdata,
  input  logic                        dsk_rd_valid,
  output logic                        dsk_rd_ready,
  input  logic [15:0]                 dsk_rd_data,
  output logic                        dsk_wr_valid,
  input  logic                        dsk_wr_ready,
  output logic [15:0]                 dsk_wr_data
);

  localparam int unsigned SCNT_W = $clog2(SEC_WORDS) + 1;
  localparam logic [18:0] LIMIT  = 19'(MEM_BYTES);

  seq_state_t        state_q;
  disk_pos_t         da_q;
  logic              fn_q, ie_q, rdy_q, ardy_q;
  logic [15:0]       err_q, hold_q;
  logic [SCNT_W-1:0] n_q;

  // named internal events
  logic        chk_bad, step_ovf, addr_bad, sec_full;
  logic        src_hs, snk_hs, accept, word_step;
  logic [15:0] chk_err;
  disk_pos_t   step_pos;
  logic [17:0] addr;
  logic [15:0] wc;
  logic        wc_last, wc_zero;

  dxs_pos_check #(.N_DRIVES(N_DRIVES), .N_CYL(N_CYL), .N_SEC(N_SEC)) u_check (
    .pos(da_q), .present(drive_present), .err_vec(chk_err), .bad(chk_bad)
  );

  dxs_pos_step #(.N_CYL(N_CYL), .N_SEC(N_SEC)) u_step (
    .pos(da_q), .next_pos(step_pos), .ovf(step_ovf)
  );

  dxs_bus_addr u_addr (
    .clk(clk), .rst_n(rst_n), .clr(ctl_reset), .load(accept),
    .ba_in(ba_in), .ext_in(ext_in), .wc_in(wc_in), .inh_in(inh_inc),
    .step(word_step), .addr(addr), .wc(wc), .wc_last(wc_last), .wc_zero(wc_zero)
  );

  assign accept    = (state_q == ST_IDLE) && start && !ctl_reset;
  assign addr_bad  = ({1'b0, addr} >= LIMIT);
  assign sec_full  = (n_q == SCNT_W'(SEC_WORDS - 1));
  assign src_hs    = fn_q ? (mem_valid && mem_ready) : (dsk_rd_valid && dsk_rd_ready);
  assign snk_hs    = fn_q ? (dsk_wr_valid && dsk_wr_ready) : (mem_valid && mem_ready);
  assign word_step = (state_q == ST_PUT) && snk_hs && !ctl_reset;

  // port drive
  assign mem_valid    = ((state_q == ST_FETCH) && fn_q) || ((state_q == ST_PUT) && !fn_q);
  assign mem_we       = (state_q == ST_PUT) && !fn_q;
  assign mem_addr     = addr;
  assign mem_wdata    = hold_q;
  assign dsk_rd_ready = (state_q == ST_FETCH) && !fn_q;
  assign dsk_wr_valid = (state_q == ST_PUT) && fn_q;
  assign dsk_wr_data  = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      da_q    <= '0;
      fn_q    <= 1'b0;
      ie_q    <= 1'b0;
      rdy_q   <= 1'b1;
      ardy_q  <= 1'b1;
      err_q   <= '0;
      hold_q  <= '0;
      n_q     <= '0;
    end else if (ctl_reset) begin
      state_q <= ST_IDLE;
      rdy_q   <= 1'b1;
      ardy_q  <= 1'b1;
      err_q   <= '0;
      n_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          fn_q    <= fn_write;
          ie_q    <= ie;
          da_q    <= disk_pos_t'(da_in);
          rdy_q   <= 1'b0;
          ardy_q  <= 1'b0;
          err_q   <= '0;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (chk_bad) begin
            err_q   <= chk_err;
            state_q <= ST_FINISH;
          end else if (wc_zero) begin
            state_q <= ST_FINISH;
          end else begin
            state_q <= ST_SEC_OPEN;
          end
        end
        ST_SEC_OPEN: begin
          n_q     <= '0;
          state_q <= ST_WORD;
        end
        ST_WORD: begin
          if (addr_bad) begin
            err_q[ERR_NXM] <= 1'b1;
            state_q        <= ST_FINISH;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (src_hs) begin
          hold_q  <= fn_q ? mem_rdata : dsk_rd_data;
          state_q <= ST_PUT;
        end
        ST_PUT: if (snk_hs) begin
          n_q     <= n_q + 1'b1;
          state_q <= (wc_last || sec_full) ? ST_SEC_CLOSE : ST_WORD;
        end
        ST_SEC_CLOSE: begin
          if (step_ovf) begin
            err_q[ERR_OVR] <= 1'b1;
            state_q        <= ST_FINISH;
          end else begin
            da_q    <= step_pos;
            state_q <= wc_zero ? ST_FINISH : ST_SEC_OPEN;
          end
        end
        ST_FINISH: begin
          rdy_q   <= 1'b1;
          ardy_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign rdy       = rdy_q;
  assign ardy      = ardy_q;
  assign done      = (state_q == ST_FINISH);
  assign irq       = done && ie_q;
  assign err_bits  = err_q;
  assign da_out    = da_q;
  assign wc_out    = wc;
  assign ba_out    = addr[15:0];
  assign ext_out   = addr[17:16];
  assign sec_open  = (state_q == ST_SEC_OPEN);
  assign sec_close = (state_q == ST_SEC_CLOSE);
  assign sec_words = n_q;

  AST_RDY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (!rdy_q && !ardy_q)); // R2

  AST_MEM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ({1'b0, mem_addr} < LIMIT)); // R6

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_valid, dsk_rd_ready, dsk_wr_valid})); // R7

  AST_NO_ZERO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |-> (wc != 16'h0000)); // R3

  AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n || ctl_reset)
    ((state_q == ST_SEC_CLOSE) && !step_ovf) |=> (da_q != $past(da_q))); // R10

  AST_OVR_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n || ctl_reset)
    ((state_q == ST_SEC_CLOSE) && step_ovf) |=> $stable(da_q)); // R11

  AST_CYL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WORD) |-> (32'(da_q.cyl) < N_CYL)); // R1

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n || ctl_reset)
    ((state_q == ST_FETCH) && start) |=> (state_q == ST_FETCH || state_q == ST_PUT)); // R12

endmodule

// File: tb/tb_disk_xfer_seq.sv
module tb_disk_xfer_seq;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, ctl_reset = 1'b0, start = 1'b0, fn_write = 1'b0;
  logic [15:0] da_in = '0, wc_in = '0, ba_in = '0;
  logic [1:0]  ext_in = '0;
  logic        inh_inc = 1'b0, ie = 1'b0;
  logic [7:0]  drive_present = 8'b0000_0101;
  logic        busy, rdy, ardy, irq, done;
  logic [15:0] err_bits, da_out, wc_out, ba_out;
  logic [1:0]  ext_out;
  logic        sec_open, sec_close;
  logic [8:0]  sec_words;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b0;
  logic [17:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        dsk_rd_valid = 1'b0, dsk_rd_ready, dsk_wr_valid, dsk_wr_ready = 1'b0;
  logic [15:0] dsk_rd_data = '0, dsk_wr_data;

  logic [15:0] mem [0:4095];
  assign mem_rdata = mem[mem_addr[12:1]];

  disk_xfer_seq #(.MEM_BYTES(32'h10100)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset), .start(start), .fn_write(fn_write),
    .da_in(da_in), .wc_in(wc_in), .ba_in(ba_in), .ext_in(ext_in), .inh_inc(inh_inc), .ie(ie),
    .drive_present(drive_present), .busy(busy), .rdy(rdy), .ardy(ardy), .irq(irq), .done(done),
    .err_bits(err_bits), .da_out(da_out), .wc_out(wc_out), .ba_out(ba_out), .ext_out(ext_out),
    .sec_open(sec_open), .sec_close(sec_close), .sec_words(sec_words),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dsk_rd_valid(dsk_rd_valid), .dsk_rd_ready(dsk_rd_ready), .dsk_rd_data(dsk_rd_data),
    .dsk_wr_valid(dsk_wr_valid), .dsk_wr_ready(dsk_wr_ready), .dsk_wr_data(dsk_wr_data)
  );

  int tests = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_da(input int d, input int c, input int s, input int sec);
    return 16'((d << 13) | (c << 5) | (s << 4) | sec);
  endfunction

  typedef struct packed {
    logic        fn;
    logic [15:0] da, wc, ba;
    logic [1:0]  ext;
    logic        inh, ie;
    logic [15:0] e_err, e_da, e_wc, e_ba;
    logic [1:0]  e_ext;
    logic [15:0] e_words;
    logic [7:0]  e_closes;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, mk_da(0,0,0,0),   16'hFFFC, 16'h0100, 2'd0, 1'b0, 1'b1, 16'h0000, mk_da(0,0,0,1),   16'h0000, 16'h0108, 2'd0, 16'd4,   8'd1},
    '{1'b1, mk_da(2,5,0,11),  16'hFED4, 16'h0200, 2'd0, 1'b0, 1'b0, 16'h0000, mk_da(2,5,1,1),   16'h0000, 16'h0458, 2'd0, 16'd300, 8'd2},
    '{1'b0, mk_da(0,202,1,11),16'hFFFE, 16'h0300, 2'd0, 1'b0, 1'b1, 16'h4000, mk_da(0,202,1,11),16'h0000, 16'h0304, 2'd0, 16'd2,   8'd1},
    '{1'b0, mk_da(0,1,0,3),   16'hFFFD, 16'hFFFC, 2'd0, 1'b0, 1'b1, 16'h0000, mk_da(0,1,0,4),   16'h0000, 16'h0002, 2'd1, 16'd3,   8'd1},
    '{1'b1, mk_da(2,0,1,0),   16'hFFFB, 16'h0040, 2'd0, 1'b1, 1'b0, 16'h0000, mk_da(2,0,1,1),   16'h0000, 16'h0040, 2'd0, 16'd5,   8'd1},
    '{1'b0, mk_da(0,3,0,0),   16'hFFFC, 16'h00FC, 2'd1, 1'b0, 1'b1, 16'h0400, mk_da(0,3,0,0),   16'hFFFE, 16'h0100, 2'd1, 16'd2,   8'd0},
    '{1'b0, mk_da(1,0,0,0),   16'hFFF0, 16'h0010, 2'd0, 1'b0, 1'b1, 16'h0080, mk_da(1,0,0,0),   16'hFFF0, 16'h0010, 2'd0, 16'd0,   8'd0},
    '{1'b0, mk_da(0,203,0,0), 16'hFFF0, 16'h0010, 2'd0, 1'b0, 1'b0, 16'h0040, mk_da(0,203,0,0), 16'hFFF0, 16'h0010, 2'd0, 16'd0,   8'd0},
    '{1'b1, mk_da(0,0,0,12),  16'hFFF0, 16'h0010, 2'd0, 1'b0, 1'b1, 16'h0020, mk_da(0,0,0,12),  16'hFFF0, 16'h0010, 2'd0, 16'd0,   8'd0},
    '{1'b0, mk_da(1,250,0,15),16'hFFF0, 16'h0010, 2'd0, 1'b0, 1'b0, 16'h0080, mk_da(1,250,0,15),16'hFFF0, 16'h0010, 2'd0, 16'd0,   8'd0},
    '{1'b0, mk_da(0,0,0,2),   16'h0000, 16'h0020, 2'd0, 1'b0, 1'b1, 16'h0000, mk_da(0,0,0,2),   16'h0000, 16'h0020, 2'd0, 16'd0,   8'd0},
    '{1'b1, mk_da(2,7,1,11),  16'hFF00, 16'h0400, 2'd0, 1'b0, 1'b1, 16'h0000, mk_da(2,8,0,0),   16'h0000, 16'h0600, 2'd0, 16'd256, 8'd1}
  };

  // port model and trace monitor
  int          cyc = 0, words = 0, closes = 0, bad = 0, irq_n = 0;
  int          rd_idx = 0, wr_idx = 0, sec_cnt = 0;
  logic [17:0] exp_addr = '0, last_addr = '0;
  logic        inh_m = 1'b0;
  logic [15:0] pos_m = '0;

  always @(negedge clk) begin
    cyc++;
    mem_ready    = (cyc % 3) != 1;
    dsk_rd_valid = (cyc % 4) != 2;
    dsk_wr_ready = (cyc % 5) != 3;
    if (sec_open) begin
      pos_m = da_out; rd_idx = 0; wr_idx = 0; sec_cnt = 0;
    end
    dsk_rd_data = pos_m ^ 16'(rd_idx);
    if (sec_close) begin
      closes++;
      if (32'(sec_words) != sec_cnt) bad++;
    end
    if (mem_valid && mem_ready) begin
      if (mem_addr != exp_addr) bad++;
      if (mem_we) begin
        if (mem_wdata != (pos_m ^ 16'(wr_idx))) bad++;
        wr_idx++; words++; sec_cnt++;
        mem[mem_addr[12:1]] = mem_wdata;
      end else begin
        last_addr = exp_addr;
      end
      if (!inh_m) exp_addr = exp_addr + 18'd2;
    end
    if (dsk_rd_valid && dsk_rd_ready) rd_idx++;
    if (dsk_wr_valid && dsk_wr_ready) begin
      if (dsk_wr_data != (16'hC000 ^ {4'h0, last_addr[12:1]})) bad++;
      words++; sec_cnt++;
    end
    if (busy && (rdy || ardy)) bad++;
    if (irq) irq_n++;
  end

  task automatic launch(input vec_t v);
    if (v.fn) for (int i = 0; i < 4096; i++) mem[i] = 16'hC000 ^ 16'(i);
    exp_addr = {v.ext, v.ba}; inh_m = v.inh;
    words = 0; closes = 0; bad = 0; irq_n = 0;
    @(negedge clk);
    fn_write = v.fn; da_in = v.da; wc_in = v.wc; ba_in = v.ba;
    ext_in = v.ext; inh_inc = v.inh; ie = v.ie; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=%0d expected=done", t);
    end
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    launch(v);
    wait_done();
    chk("R1/R6/R11 err_bits", 32'(err_bits), 32'(v.e_err));
    chk("R10/R11 da_out",     32'(da_out),   32'(v.e_da));
    chk("R3 wc_out",          32'(wc_out),   32'(v.e_wc));
    chk("R4/R5 ba_out",       32'(ba_out),   32'(v.e_ba));
    chk("R4 ext_out",         32'(ext_out),  32'(v.e_ext));
    chk("R3/R8 words moved",  32'(words),    32'(v.e_words));
    chk("R9 sector closes",   32'(closes),   32'(v.e_closes));
    chk("R2 irq pulses",      32'(irq_n),    32'(v.ie));
    chk("R7/R8 trace errors", 32'(bad),      32'd0);
    chk("R2 ready after",     {30'd0, rdy, ardy}, 32'd3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset rdy/ardy", {30'd0, rdy, ardy}, 32'd3);
    chk("R13 reset busy",    32'(busy), 32'd0);
    chk("R13 reset err",     32'(err_bits), 32'd0);
    chk("R13 reset valids",  {29'd0, mem_valid, dsk_rd_ready, dsk_wr_valid}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R12: start during a run is ignored
    v = VECS[0];
    v.wc = 16'hFFEC; v.ba = 16'h0800; v.ie = 1'b0;
    launch(v);
    repeat (10) @(negedge clk);
    fn_write = 1'b1; da_in = mk_da(2,9,0,0); wc_in = 16'hFFFF; ba_in = 16'h0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R12 da after ignored start",    32'(da_out), 32'(mk_da(0,0,0,1)));
    chk("R12 ba after ignored start",    32'(ba_out), 32'h0828);
    chk("R12 words after ignored start", 32'(words),  32'd20);
    chk("R12 trace",                     32'(bad),    32'd0);

    // R13: controller reset in mid-transfer
    v.wc = 16'hFFD8; v.ba = 16'h1000; v.ie = 1'b1;
    launch(v);
    repeat (15) @(negedge clk);
    ctl_reset = 1'b1;
    @(negedge clk);
    ctl_reset = 1'b0;
    chk("R13 busy after ctl_reset",  32'(busy), 32'd0);
    chk("R13 ready after ctl_reset", {30'd0, rdy, ardy}, 32'd3);
    chk("R13 err after ctl_reset",   32'(err_bits), 32'd0);
    chk("R13 wc after ctl_reset",    32'(wc_out), 32'd0);
    repeat (3) @(negedge clk);
    chk("R13 no handshake offered",  {29'd0, mem_valid, dsk_rd_ready, dsk_wr_valid}, 32'd0);

    run_vec(VECS[0]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule